// File: doc/BRIEF.md
# Event Status and Interrupt Controller

This block holds a four-bit status word for a signal-processing core: a command-ready flag, a tone-generator-active flag, a tone-detected flag and an abort flag. The core reports single-cycle event pulses, such as command complete, command issued, generator start or stop, tone found or lost and exception. It also drives an enable level and a strobe once per 125 us frame. The block turns these into status-bit changes. Some changes take effect at once. Others wait for a later trigger. While a host access is in progress, all status changes are held back.

Five specific status transitions are interrupt events. When one of them is applied and its source is not masked, a level interrupt output is raised. The host talks to the block over a bit-serial port with a select, a bit strobe, a data input and a data output. Over this port it can read the status, read the status with an acknowledge that drops the interrupt, write a mask, and read or write a revision register. After an exception, the block locks out every host command except a revision write, and that write is the only way to clear the abort flag.

Top module: `evt_stat_irq`

## Requirements
- R1: After reset the status word is 0, the interrupt output is 0, the serial output is 0 and every mask bit is 0 (unmasked).
- R2: Status bit 0 (ready) is set by a command-complete pulse and cleared by a command-issued pulse. Its 0-to-1 change is an interrupt event and its 1-to-0 change is not.
- R3: Status bit 2 (tone detected) is set by a tone-found pulse in the cycle after the pulse while enable is high. Both its rise and its fall are interrupt events.
- R4: A tone-lost request does not clear bit 2 at once. The clear is applied together with the next ready-bit update, or at the next frame strobe, whichever comes first.
- R5: Status bit 1 (generator active) is set by a generator-start pulse, and that rise raises no interrupt. A generator-stop request clears the bit only at the next frame strobe, and that fall is an interrupt event.
- R6: While enable is low, generator-start and tone-found pulses are ignored, and clear requests for bits 1 and 2 are posted as if stop and tone-lost had been signalled.
- R7: Mask bit 0 covers ready, bit 1 covers generator and bit 2 covers tone detected. A set mask bit stops that source from raising the interrupt but still lets its status bit change. The mask is loaded from data bits [2:0] of a command with opcode 3'b001.
- R8: A transfer is 8 command bits followed by 8 data bits, MSB first, one bit per strobe while select is high. The opcode is command bits [7:5]. Opcode 3'b010 reads the status as the byte {4'b0, abort, tone, generator, ready}. The serial output presents each data bit after the strobe that precedes it, so the MSB is presented after the 8th strobe.
- R9: A status read with acknowledge (opcode 3'b011) drops the interrupt at the 9th strobe, which shifts out the first data bit. A plain status read leaves the interrupt unchanged.
- R10: While select is high, no status bit is set or cleared by an event and no interrupt is raised. Events seen during that time are applied, and any interrupt raised, in the cycle after select falls.
- R11: An exception pulse sets status bit 3 (abort). Its rise always raises the interrupt, whatever the mask holds, and returns the mask to its reset value.
- R12: While abort is set, every command except opcode 3'b101 is discarded: reads return all zeros, a read with acknowledge leaves the interrupt set, and mask writes have no effect.
- R13: A revision write (opcode 3'b101, any data) clears abort and leaves the revision value unchanged. A revision read (opcode 3'b100) returns the fixed value 8'h3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enI | input | 1 | Tone function enable level |
| cmdDoneI | input | 1 | Command complete pulse |
| cmdIssueI | input | 1 | Command issued pulse |
| genStartI | input | 1 | Tone generator start pulse |
| genStopI | input | 1 | Tone sequence finished pulse |
| toneOnI | input | 1 | Tone found pulse |
| toneOffI | input | 1 | Tone lost pulse |
| abortI | input | 1 | Exception pulse |
| frameTickI | input | 1 | One-cycle strobe per 125 us frame |
| hostSelI | input | 1 | Host access select, high for a whole transfer |
| hostStbI | input | 1 | Serial bit strobe |
| hostDinI | input | 1 | Serial data from host |
| hostDoutO | output | 1 | Serial data to host |
| irqO | output | 1 | Interrupt request level |
| statO | output | 4 | Status word {abort, tone, generator, ready} |

## Verification
Several properties are checked on every cycle. The status is frozen while select is high, except that abort may fall. The interrupt never rises during an access and only rises when the status has changed. It only falls right after a strobe inside an access. Every rise of abort comes with a raised interrupt. The timing of the deferred clears can only be shown by the directed scenarios: the tone-lost clear landing with the ready update or with the frame strobe, and the generator clear waiting for the frame strobe. The same holds for the mask filtering events, the exact strobe at which the acknowledge drops the interrupt, and the abort lockout with its recovery through the revision write.

// File: rtl/esi_pkg.sv
`timescale 1ns/1ps
package esi_pkg;
  localparam int STAT_W = 4;
  localparam int NSRC   = 3;
  localparam int CMD_W  = 8;
  localparam int DAT_W  = 8;
  localparam int OP_W   = 3;
  localparam int FRM_W  = CMD_W + DAT_W;
  localparam int CNT_W  = $clog2(FRM_W + 1);

  localparam int B_RDY = 0;
  localparam int B_TG  = 1;
  localparam int B_DTV = 2;
  localparam int B_ABT = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 3'd0,
    OP_WMASK = 3'd1,
    OP_RSTAT = 3'd2,
    OP_RACK  = 3'd3,
    OP_RREV  = 3'd4,
    OP_WREV  = 3'd5
  } op_e;

  typedef struct packed {
    logic            busy;
    logic            ackStb;
    logic            maskWr;
    logic            abtClr;
    logic            ldStat;
    logic            ldRev;
    logic            shiftStb;
    logic [NSRC-1:0] wrMask;
  } ctl_t;
endpackage

// File: rtl/esi_ctrl.sv
`timescale 1ns/1ps
module esi_ctrl
  import esi_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hostSel,
  input  logic hostStb,
  input  logic hostDin,
  input  logic abtLock,
  output ctl_t ctl
);
  logic [CNT_W-1:0] bitCnt;
  logic [CMD_W-2:0] inSh;
  logic [OP_W-1:0]  opQ;
  logic             opOk;

  logic             strobe;
  logic             cmdEnd;
  logic             datEnd;
  logic             firstOut;
  logic [OP_W-1:0]  decOp;
  logic             decOk;

  always_comb begin
    strobe   = hostSel && hostStb && (bitCnt < CNT_W'(FRM_W));
    cmdEnd   = strobe && (bitCnt == CNT_W'(CMD_W - 1));
    datEnd   = strobe && (bitCnt == CNT_W'(FRM_W - 1));
    firstOut = strobe && (bitCnt == CNT_W'(CMD_W));
    decOp    = inSh[CMD_W-2 -: OP_W];
    decOk    = !abtLock || (decOp == OP_WREV);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      inSh   <= '0;
      opQ    <= OP_NONE;
      opOk   <= 1'b0;
    end else if (!hostSel) begin
      bitCnt <= '0;
      opQ    <= OP_NONE;
      opOk   <= 1'b0;
    end else if (strobe) begin
      bitCnt <= bitCnt + 1'b1;
      inSh   <= {inSh[CMD_W-3:0], hostDin};
      if (cmdEnd) begin
        opQ  <= decOp;
        opOk <= decOk;
      end
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.busy     = hostSel;
    ctl.ldStat   = cmdEnd && decOk && ((decOp == OP_RSTAT) || (decOp == OP_RACK));
    ctl.ldRev    = cmdEnd && decOk && (decOp == OP_RREV);
    ctl.shiftStb = strobe && (bitCnt >= CNT_W'(CMD_W));
    ctl.ackStb   = firstOut && opOk && (opQ == OP_RACK);
    ctl.maskWr   = datEnd && opOk && !abtLock && (opQ == OP_WMASK);
    ctl.abtClr   = datEnd && (opQ == OP_WREV);
    ctl.wrMask   = {inSh[NSRC-2:0], hostDin};
  end
endmodule

// File: rtl/esi_dpath.sv
`timescale 1ns/1ps
module esi_dpath
  import esi_pkg::*;
#(
  parameter logic [NSRC-1:0]  MASK_RST = '0,
  parameter logic [DAT_W-1:0] REV_ID   = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              cmdDone,
  input  logic              cmdIssue,
  input  logic              genStart,
  input  logic              genStop,
  input  logic              toneOn,
  input  logic              toneOff,
  input  logic              abortEv,
  input  logic              frameTick,
  input  ctl_t              ctl,
  output logic [STAT_W-1:0] stat,
  output logic              irq,
  output logic              dout
);
  localparam logic [NSRC-1:0] RISE_EV = NSRC'((1 << B_RDY) | (1 << B_DTV));
  localparam logic [NSRC-1:0] FALL_EV = NSRC'((1 << B_TG) | (1 << B_DTV));

  logic [NSRC-1:0]  mask;
  logic [DAT_W-1:0] rdSh;
  logic rdySetP, rdyClrP, tgSetP, tgClrP, tgClrDue, dtvSetP, dtvClrP, dtvClrDue, abtP;

  logic go;
  logic rdySetE, rdyClrE, rdyUpd;
  logic tgSetIn, tgClrIn, tgSetE, tgClrE, tgDueE;
  logic dtvSetIn, dtvClrIn, dtvSetE, dtvClrE, dtvDueE;
  logic abtE, abtRise, irqSet;
  logic [STAT_W-1:0] statN;
  logic [NSRC-1:0]   srcEv;

  always_comb begin
    go       = !ctl.busy;
    rdySetE  = cmdDone | (rdySetP & !cmdIssue);
    rdyClrE  = !cmdDone & (cmdIssue | rdyClrP);
    rdyUpd   = rdySetE | rdyClrE;

    tgSetIn  = en & genStart;
    tgClrIn  = genStop | !en;
    tgSetE   = tgSetIn | (tgSetP & !tgClrIn);
    tgClrE   = !tgSetIn & (tgClrIn | tgClrP);
    tgDueE   = tgClrE & (tgClrDue | frameTick);

    dtvSetIn = en & toneOn;
    dtvClrIn = toneOff | !en;
    dtvSetE  = dtvSetIn | (dtvSetP & !dtvClrIn);
    dtvClrE  = !dtvSetIn & (dtvClrIn | dtvClrP);
    dtvDueE  = dtvClrE & (dtvClrDue | frameTick | rdyUpd);

    abtE     = abortEv | abtP;

    statN = stat;
    if (go) begin
      if (rdySetE)      statN[B_RDY] = 1'b1;
      else if (rdyClrE) statN[B_RDY] = 1'b0;
      if (tgSetE)       statN[B_TG]  = 1'b1;
      else if (tgDueE)  statN[B_TG]  = 1'b0;
      if (dtvSetE)      statN[B_DTV] = 1'b1;
      else if (dtvDueE) statN[B_DTV] = 1'b0;
      if (abtE)         statN[B_ABT] = 1'b1;
    end
    if (ctl.abtClr)     statN[B_ABT] = 1'b0;

    abtRise = statN[B_ABT] & !stat[B_ABT];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign srcEv[i] = ((RISE_EV[i] & statN[i] & !stat[i]) |
                       (FALL_EV[i] & !statN[i] & stat[i])) & !mask[i];
  end

  assign irqSet = (|srcEv) | abtRise;
  assign dout   = rdSh[DAT_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat      <= '0;
      irq       <= 1'b0;
      mask      <= MASK_RST;
      rdSh      <= '0;
      rdySetP   <= 1'b0;
      rdyClrP   <= 1'b0;
      tgSetP    <= 1'b0;
      tgClrP    <= 1'b0;
      tgClrDue  <= 1'b0;
      dtvSetP   <= 1'b0;
      dtvClrP   <= 1'b0;
      dtvClrDue <= 1'b0;
      abtP      <= 1'b0;
    end else begin
      stat <= statN;

      if (irqSet)          irq <= 1'b1;
      else if (ctl.ackStb) irq <= 1'b0;

      if (abtRise)         mask <= MASK_RST;
      else if (ctl.maskWr) mask <= ctl.wrMask;

      if (!ctl.busy)         rdSh <= '0;
      else if (ctl.ldStat)   rdSh <= DAT_W'(stat);
      else if (ctl.ldRev)    rdSh <= REV_ID;
      else if (ctl.shiftStb) rdSh <= {rdSh[DAT_W-2:0], 1'b0};

      if (go) begin
        rdySetP   <= 1'b0;
        rdyClrP   <= 1'b0;
        tgSetP    <= 1'b0;
        tgClrP    <= tgClrE & !tgDueE;
        tgClrDue  <= 1'b0;
        dtvSetP   <= 1'b0;
        dtvClrP   <= dtvClrE & !dtvDueE;
        dtvClrDue <= 1'b0;
        abtP      <= 1'b0;
      end else begin
        rdySetP   <= rdySetE;
        rdyClrP   <= rdyClrE;
        tgSetP    <= tgSetE;
        tgClrP    <= tgClrE;
        tgClrDue  <= tgDueE;
        dtvSetP   <= dtvSetE;
        dtvClrP   <= dtvClrE;
        dtvClrDue <= dtvDueE;
        abtP      <= abtE;
      end
    end
  end
endmodule

// File: rtl/evt_stat_irq.sv
`timescale 1ns/1ps
module evt_stat_irq
  import esi_pkg::*;
#(
  parameter logic [NSRC-1:0]  MASK_RST = '0,
  parameter logic [DAT_W-1:0] REV_ID   = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enI,
  input  logic              cmdDoneI,
  input  logic              cmdIssueI,
  input  logic              genStartI,
  input  logic              genStopI,
  input  logic              toneOnI,
  input  logic              toneOffI,
  input  logic              abortI,
  input  logic              frameTickI,
  input  logic              hostSelI,
  input  logic              hostStbI,
  input  logic              hostDinI,
  output logic              hostDoutO,
  output logic              irqO,
  output logic [STAT_W-1:0] statO
);
  ctl_t ctl;

  esi_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostSel (hostSelI),
    .hostStb (hostStbI),
    .hostDin (hostDinI),
    .abtLock (statO[B_ABT]),
    .ctl     (ctl)
  );

  esi_dpath #(.MASK_RST(MASK_RST), .REV_ID(REV_ID)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .en        (enI),
    .cmdDone   (cmdDoneI),
    .cmdIssue  (cmdIssueI),
    .genStart  (genStartI),
    .genStop   (genStopI),
    .toneOn    (toneOnI),
    .toneOff   (toneOffI),
    .abortEv   (abortI),
    .frameTick (frameTickI),
    .ctl       (ctl),
    .stat      (statO),
    .irq       (irqO),
    .dout      (hostDoutO)
  );
endmodule

// File: rtl/esi_chk.sv
`timescale 1ns/1ps
module esi_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostSelI,
  input logic       hostStbI,
  input logic       irqO,
  input logic [3:0] statO
);
  p_hold_access_r10: assert property (@(posedge clk) disable iff (!rstN)
    hostSelI |=> ($stable(statO[2:0]) && !$rose(statO[3])));

  p_no_irq_in_access_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqO) |-> !$past(hostSelI));

  p_irq_drop_by_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqO) |-> $past(hostSelI && hostStbI));

  p_abort_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statO[3]) |-> irqO);

  p_irq_needs_change_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqO) |-> (statO != $past(statO)));
endmodule

bind evt_stat_irq esi_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostSelI (hostSelI),
  .hostStbI (hostStbI),
  .irqO     (irqO),
  .statO    (statO)
);

// File: tb/test_evt_stat_irq.sv
`timescale 1ns/1ps
module test_evt_stat_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enI = 1'b1;
  logic cmdDoneI = 0, cmdIssueI = 0, genStartI = 0, genStopI = 0;
  logic toneOnI = 0, toneOffI = 0, abortI = 0, frameTickI = 0;
  logic hostSelI = 0, hostStbI = 0, hostDinI = 0;
  logic hostDoutO, irqO;
  logic [3:0] statO;

  int nRun = 0;
  int nFail = 0;

  localparam logic [7:0] C_WMASK = 8'h20;
  localparam logic [7:0] C_RSTAT = 8'h40;
  localparam logic [7:0] C_RACK  = 8'h60;
  localparam logic [7:0] C_RREV  = 8'h80;
  localparam logic [7:0] C_WREV  = 8'hA0;
  localparam logic [7:0] REV_VAL = 8'h3C;

  always #2 clk = ~clk;

  evt_stat_irq i_evt_stat_irq (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    case (which)
      0: cmdDoneI = 1;  1: cmdIssueI = 1; 2: genStartI = 1; 3: genStopI = 1;
      4: toneOnI = 1;   5: toneOffI = 1;  6: abortI = 1;    default: frameTickI = 1;
    endcase
    @(negedge clk);
    {cmdDoneI, cmdIssueI, genStartI, genStopI, toneOnI, toneOffI, abortI, frameTickI} = '0;
  endtask

  task automatic hostBit(input logic b, output logic o);
    o = hostDoutO;
    hostDinI = b;
    hostStbI = 1;
    @(negedge clk);
    hostStbI = 0;
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, output logic [7:0] rd);
    logic o;
    hostSelI = 1;
    for (int i = 0; i < 8; i++) hostBit(cmd[7-i], o);
    for (int i = 0; i < 8; i++) begin
      hostBit(dat[7-i], o);
      rd[7-i] = o;
    end
    hostSelI = 0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1", "status", statO, 0);
    check("R1", "irq", irqO, 0);
    check("R1", "dout", hostDoutO, 0);
  endtask

  task automatic testReady();
    logic [7:0] rd;
    logic o;
    pulse(0);
    check("R2", "ready set", statO, 4'b0001);
    check("R2", "ready rise irq", irqO, 1);
    xfer(C_RSTAT, 8'h00, rd);
    check("R8", "status byte", rd, 8'h01);
    check("R9", "plain read keeps irq", irqO, 1);
    hostSelI = 1;
    for (int i = 0; i < 8; i++) hostBit(C_RACK[7-i], o);
    check("R9", "irq before first data bit", irqO, 1);
    hostBit(1'b0, o);
    check("R9", "irq after first data bit", irqO, 0);
    for (int i = 1; i < 8; i++) hostBit(1'b0, o);
    hostSelI = 0;
    @(negedge clk);
    pulse(1);
    check("R2", "ready clear", statO, 4'b0000);
    check("R2", "ready fall no irq", irqO, 0);
  endtask

  task automatic testMask();
    logic [7:0] rd;
    xfer(C_WMASK, 8'h01, rd);
    pulse(0);
    check("R7", "masked ready still sets", statO, 4'b0001);
    check("R7", "masked ready no irq", irqO, 0);
    pulse(1);
    xfer(C_WMASK, 8'h00, rd);
    check("R7", "status after unmask", statO, 4'b0000);
  endtask

  task automatic testTone();
    logic [7:0] rd;
    pulse(4);
    check("R3", "tone set", statO, 4'b0100);
    check("R3", "tone rise irq", irqO, 1);
    xfer(C_RACK, 8'h00, rd);
    check("R8", "tone byte", rd, 8'h04);
    pulse(5);
    repeat (3) @(negedge clk);
    check("R4", "tone clear deferred", statO, 4'b0100);
    check("R4", "no irq yet", irqO, 0);
    pulse(0);
    check("R4", "clear with ready update", statO, 4'b0001);
    check("R3", "tone fall irq", irqO, 1);
    xfer(C_RACK, 8'h00, rd);
    pulse(4);
    xfer(C_RACK, 8'h00, rd);
    pulse(5);
    @(negedge clk);
    check("R4", "still set before tick", statO, 4'b0101);
    pulse(7);
    check("R4", "clear on frame tick", statO, 4'b0001);
    check("R4", "irq on tick clear", irqO, 1);
    xfer(C_RACK, 8'h00, rd);
  endtask

  task automatic testGen();
    logic [7:0] rd;
    pulse(2);
    check("R5", "gen set", statO, 4'b0011);
    check("R5", "gen rise no irq", irqO, 0);
    pulse(3);
    repeat (2) @(negedge clk);
    check("R5", "gen clear waits tick", statO, 4'b0011);
    pulse(7);
    check("R5", "gen clear at tick", statO, 4'b0001);
    check("R5", "gen fall irq", irqO, 1);
    xfer(C_RACK, 8'h00, rd);
  endtask

  task automatic testEnable();
    logic [7:0] rd;
    pulse(2);
    pulse(4);
    check("R6", "both set with enable", statO, 4'b0111);
    xfer(C_RACK, 8'h00, rd);
    enI = 0;
    pulse(2);
    pulse(4);
    check("R6", "no clear before tick", statO, 4'b0111);
    pulse(7);
    check("R6", "enable low clears", statO, 4'b0001);
    check("R6", "irq from clears", irqO, 1);
    xfer(C_RACK, 8'h00, rd);
    pulse(4);
    pulse(7);
    check("R6", "set ignored when disabled", statO, 4'b0001);
    enI = 1;
    @(negedge clk);
  endtask

  task automatic testHold();
    logic [7:0] rd;
    hostSelI = 1;
    @(negedge clk);
    pulse(4);
    repeat (2) @(negedge clk);
    check("R10", "held during access", statO, 4'b0001);
    check("R10", "no irq during access", irqO, 0);
    hostSelI = 0;
    @(negedge clk);
    check("R10", "applied after access", statO, 4'b0101);
    check("R10", "irq after access", irqO, 1);
    xfer(C_RACK, 8'h00, rd);
  endtask

  task automatic testAbort();
    logic [7:0] rd;
    xfer(C_WMASK, 8'h07, rd);
    pulse(6);
    check("R11", "abort set", statO, 4'b1101);
    check("R11", "abort irq despite mask", irqO, 1);
    xfer(C_RACK, 8'h00, rd);
    check("R12", "read discarded", rd, 8'h00);
    check("R12", "ack discarded", irqO, 1);
    xfer(C_RREV, 8'h00, rd);
    check("R12", "rev read discarded", rd, 8'h00);
    xfer(C_WMASK, 8'h07, rd);
    xfer(C_WREV, 8'h55, rd);
    check("R13", "abort cleared", statO, 4'b0101);
    xfer(C_RACK, 8'h00, rd);
    check("R13", "status after recovery", rd, 8'h05);
    check("R13", "ack works again", irqO, 0);
    pulse(5);
    pulse(7);
    check("R11", "mask reset by abort", irqO, 1);
    check("R12", "mask write discarded", statO, 4'b0001);
    xfer(C_RREV, 8'h00, rd);
    check("R13", "revision unchanged", rd, REV_VAL);
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testReady();
    testMask();
    testTone();
    testGen();
    testEnable();
    testHold();
    testAbort();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule